// File: doc/BRIEF.md
# Width-Selectable ALU with Status Flag Register

This block performs addition, subtraction, AND, OR and bitwise inversion on operands that are either byte-wide or word-wide. A single `wide` input selects the width for each operation. The result and a nine-bit status register are registered. The arithmetic status bits are carry, parity, half-carry (auxiliary), zero, sign and overflow, and they are derived at the width in use. Three control bits (trap, interrupt enable, direction) live in the same register. Only dedicated set and clear commands change them.

A transfer command passes operand B to the result but leaves every flag as it was. This is the path for data moves and program-control operations. Codes without a defined meaning, and cycles with `op_valid` low, change nothing. A core sequencer drives one command per cycle. It reads the result and the flags on the following cycle.

Top module: `alu_flag_unit`

## Requirements
- R1: After reset, `result` is 0 and `flags` is 0. The bit positions in `flags` are: 0 carry, 1 parity, 2 auxiliary, 3 zero, 4 sign, 5 overflow, 6 trap, 7 interrupt enable, 8 direction.
- R2: Command codes are 0 add, 1 subtract (A minus B), 2 AND, 3 OR, 4 NOT A, and 5 transfer B. For each of these with `op_valid` high, `result` holds the outcome one clock later. When `wide` is 0, only bits 7:0 of the operands are used and bits 15:8 of `result` are 0.
- R3: On an add, carry is the carry out of the top bit at the selected width. On a subtract, carry is 1 exactly when B is greater than A at that width, which means a borrow.
- R4: Parity is 1 when bits 7:0 of the result hold an even number of ones, and 0 otherwise. A result of 0 gives parity 1.
- R5: Auxiliary is the carry from bit 3 into bit 4 on an add, or the borrow from bit 4 into bit 3 on a subtract.
- R6: Zero is 1 exactly when the result at the selected width is 0.
- R7: Sign equals bit 7 of the result for byte width and bit 15 for word width.
- R8: Overflow is 1 when the signed result does not fit the selected width. For example, a byte-wide add of 0x7F and 0x01 gives 0x80 with overflow set.
- R9: AND, OR and NOT clear carry, overflow and auxiliary, and they update parity, zero and sign from the result.
- R10: Transfer (code 5), codes 12 to 15, and any cycle with `op_valid` low leave all flags unchanged. Codes 12 to 15 and idle cycles also leave `result` unchanged.
- R11: Codes 6 and 7 set and clear interrupt enable, codes 8 and 9 set and clear direction, and codes 10 and 11 set and clear trap. These commands leave the arithmetic flags and `result` unchanged. Arithmetic and logic commands never change the control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A command is present this cycle |
| op_code | input | 4 | Command code (see R2, R11) |
| wide | input | 1 | 1 = word width, 0 = byte width |
| opnd_a | input | 16 | Operand A |
| opnd_b | input | 16 | Operand B |
| result | output | 16 | Registered result |
| flags | output | 9 | Status register (layout in R1) |

## Verification
Every result and every flag change is due exactly one rising edge after the command is presented. The bench drives each command on a falling edge, removes it at the next falling edge, and samples `result` and `flags` at that same moment. That moment falls half a period after the capturing edge. The bench tracks the expected register contents across commands, so a flag held by a transfer or control command is compared against the value left by earlier arithmetic. Idle cycles are sampled the same way to show that nothing moved.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

   typedef enum logic [3:0] {
      OP_ADD  = 4'h0,
      OP_SUB  = 4'h1,
      OP_AND  = 4'h2,
      OP_OR   = 4'h3,
      OP_NOT  = 4'h4,
      OP_MOVE = 4'h5,
      OP_SETI = 4'h6,
      OP_CLRI = 4'h7,
      OP_SETD = 4'h8,
      OP_CLRD = 4'h9,
      OP_SETT = 4'hA,
      OP_CLRT = 4'hB
   } alu_op_e;

   localparam int FLAG_N = 9;
   localparam int FL_C   = 0;
   localparam int FL_P   = 1;
   localparam int FL_A   = 2;
   localparam int FL_Z   = 3;
   localparam int FL_S   = 4;
   localparam int FL_O   = 5;
   localparam int FL_T   = 6;
   localparam int FL_I   = 7;
   localparam int FL_D   = 8;
   localparam int CTRL_N = 3;

   typedef struct packed {
      logic ovf;
      logic sgn;
      logic zro;
      logic aux;
      logic par;
      logic cry;
   } arith_flags_t;

endpackage

// File: rtl/alu_parity.sv
module alu_parity #(
   parameter int IN_W = 8
) (
   input  logic [IN_W-1:0] d,
   output logic            even
);
   logic [IN_W:0] chain;

   assign chain[0] = 1'b1;
   for (genvar i = 0; i < IN_W; i++) begin : g_chain
      assign chain[i+1] = chain[i] ^ d[i];
   end
   assign even = chain[IN_W];
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
   import alu_flag_pkg::*;
#(
   parameter int W     = 16,
   parameter int PAR_W = 8
) (
   input  alu_op_e        op,
   input  logic           wide,
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [W-1:0]   res,
   output arith_flags_t   af
);
   localparam int NW      = W / 2;
   localparam int AUX_POS = 4;

   logic [W-1:0] mask, am, bm, raw, hx;
   logic [W:0]   sum, diff;
   logic         sa, sb, sr, par_even;

   always_comb begin
      mask = wide ? {W{1'b1}} : {{(W-NW){1'b0}}, {NW{1'b1}}};
      am   = a & mask;
      bm   = b & mask;
      sum  = {1'b0, am} + {1'b0, bm};
      diff = {1'b0, am} - {1'b0, bm};
      sa   = wide ? am[W-1] : am[NW-1];
      sb   = wide ? bm[W-1] : bm[NW-1];
      raw  = '0;
      af   = '0;
      case (op)
         OP_ADD: begin
            raw    = sum[W-1:0];
            af.cry = wide ? sum[W] : sum[NW];
         end
         OP_SUB: begin
            raw    = diff[W-1:0];
            af.cry = wide ? diff[W] : diff[NW];
         end
         OP_AND:  raw = am & bm;
         OP_OR:   raw = am | bm;
         OP_NOT:  raw = ~am;
         OP_MOVE: raw = bm;
         default: raw = '0;
      endcase
      res = raw & mask;
      hx  = am ^ bm ^ res;
      sr  = wide ? res[W-1] : res[NW-1];
      if (op == OP_ADD) begin
         af.aux = hx[AUX_POS];
         af.ovf = (sa == sb) && (sr != sa);
      end else if (op == OP_SUB) begin
         af.aux = hx[AUX_POS];
         af.ovf = (sa != sb) && (sr != sa);
      end
      af.zro = (res == '0);
      af.sgn = sr;
      af.par = par_even;
   end

   alu_parity #(.IN_W(PAR_W)) u_par (
      .d    (res[PAR_W-1:0]),
      .even (par_even)
   );
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
   import alu_flag_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_arith,
   input  arith_flags_t      af_in,
   input  logic [CTRL_N-1:0] ctrl_set,
   input  logic [CTRL_N-1:0] ctrl_clr,
   output logic [FLAG_N-1:0] flags
);
   arith_flags_t      arith_q;
   logic [CTRL_N-1:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         arith_q <= '0;
      else if (upd_arith) arith_q <= af_in;
   end

   for (genvar k = 0; k < CTRL_N; k++) begin : g_ctrl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           ctrl_q[k] <= 1'b0;
         else if (ctrl_set[k]) ctrl_q[k] <= 1'b1;
         else if (ctrl_clr[k]) ctrl_q[k] <= 1'b0;
      end
   end

   assign flags = {ctrl_q, arith_q.ovf, arith_q.sgn, arith_q.zro,
                   arith_q.aux, arith_q.par, arith_q.cry};
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
   import alu_flag_pkg::*;
#(
   parameter int W     = 16,
   parameter int PAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [3:0]        op_code,
   input  logic              wide,
   input  logic [W-1:0]      opnd_a,
   input  logic [W-1:0]      opnd_b,
   output logic [W-1:0]      result,
   output logic [FLAG_N-1:0] flags
);
   localparam int NW = W / 2;

   if ((W % 2) != 0 || W < 16) begin : g_bad_w
      $error("alu_flag_unit: W must be even and at least 16");
   end
   if (PAR_W < 1 || PAR_W > NW) begin : g_bad_p
      $error("alu_flag_unit: PAR_W must lie in 1..W/2");
   end

   alu_op_e           op_e;
   logic              is_alu, is_logic, is_move;
   logic [W-1:0]      dp_res;
   arith_flags_t      dp_af;
   logic [CTRL_N-1:0] ctrl_set, ctrl_clr;

   always_comb begin
      op_e     = alu_op_e'(op_code);
      is_logic = (op_e == OP_AND) || (op_e == OP_OR) || (op_e == OP_NOT);
      is_alu   = (op_e == OP_ADD) || (op_e == OP_SUB) || is_logic;
      is_move  = (op_e == OP_MOVE);
      ctrl_set = {CTRL_N{op_valid}} &
                 {op_e == OP_SETD, op_e == OP_SETI, op_e == OP_SETT};
      ctrl_clr = {CTRL_N{op_valid}} &
                 {op_e == OP_CLRD, op_e == OP_CLRI, op_e == OP_CLRT};
   end

   alu_datapath #(.W(W), .PAR_W(PAR_W)) u_dp (
      .op   (op_e),
      .wide (wide),
      .a    (opnd_a),
      .b    (opnd_b),
      .res  (dp_res),
      .af   (dp_af)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              result <= '0;
      else if (op_valid && (is_alu || is_move)) result <= dp_res;
   end

   alu_flag_reg u_fr (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_arith (op_valid && is_alu),
      .af_in     (dp_af),
      .ctrl_set  (ctrl_set),
      .ctrl_clr  (ctrl_clr),
      .flags     (flags)
   );

   // R6
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && is_alu |=> flags[FL_Z] == (result == '0));

   // R4
   parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && is_alu |=> flags[FL_P] == ~^result[PAR_W-1:0]);

   // R7
   sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && is_alu |=>
         flags[FL_S] == ($past(wide) ? result[W-1] : result[NW-1]));

   // R9
   logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && is_logic |=> !flags[FL_C] && !flags[FL_O] && !flags[FL_A]);

   // R10
   move_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && is_move |=> $stable(flags));

   // R11
   int_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_e == OP_SETI |=> flags[FL_I] && $stable(result));

   // R2
   narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && (is_alu || is_move) && !wide |=> result[W-1:NW] == '0);

   // R11
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && is_alu |=> $stable(flags[FLAG_N-1:FL_T]));
endmodule

// File: tb/sim_alu_flag_unit.sv
module sim_alu_flag_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  op_code = '0;
   logic        wide = 1'b0;
   logic [15:0] opnd_a = '0, opnd_b = '0;
   logic [15:0] result;
   logic [8:0]  flags;

   int n_run = 0, n_fail = 0;
   logic [15:0] exp_res = '0;
   logic [8:0]  exp_fl = '0;

   always #2.5 clk = ~clk;

   alu_flag_unit u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .wide(wide), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .result(result), .flags(flags)
   );

   function automatic logic even8(int v);
      int c = 0;
      for (int i = 0; i < 8; i++) c += (v >> i) & 1;
      return (c % 2) == 0;
   endfunction

   function automatic string tag_of(int bitn, int op);
      if (op >= 2 && op <= 4 && (bitn == 0 || bitn == 2 || bitn == 5)) return "R9";
      case (bitn)
         0: return "R3";
         1: return "R4";
         2: return "R5";
         3: return "R6";
         4: return "R7";
         5: return "R8";
         default: return "R11";
      endcase
   endfunction

   // bench model of one command, applied to exp_res / exp_fl
   task automatic model(int op, bit wd, int a, int b);
      int lim = wd ? 65536 : 256;
      int half = lim / 2;
      int am = a % lim, bm = b % lim;
      int sa = (am >= half) ? am - lim : am;
      int sb = (bm >= half) ? bm - lim : bm;
      int r = 0, ss = 0;
      bit c = 0, ax = 0, o = 0;
      case (op)
         0: begin r = (am + bm) % lim; c = (am + bm) >= lim;
                  ax = (am % 16 + bm % 16) > 15; ss = sa + sb;
                  o = (ss > half - 1) || (ss < -half); end
         1: begin r = (am - bm + lim) % lim; c = am < bm;
                  ax = (am % 16) < (bm % 16); ss = sa - sb;
                  o = (ss > half - 1) || (ss < -half); end
         2: r = am & bm;
         3: r = am | bm;
         4: r = (lim - 1) - am;
         default: r = 0;
      endcase
      if (op <= 4) begin
         exp_res = 16'(r);
         exp_fl[5:0] = {o, (r >= half), (r == 0), ax, even8(r), c};
      end else if (op == 5) exp_res = 16'(bm);
      else if (op == 6)  exp_fl[7] = 1'b1;
      else if (op == 7)  exp_fl[7] = 1'b0;
      else if (op == 8)  exp_fl[8] = 1'b1;
      else if (op == 9)  exp_fl[8] = 1'b0;
      else if (op == 10) exp_fl[6] = 1'b1;
      else if (op == 11) exp_fl[6] = 1'b0;
   endtask

   task automatic compare(int op, string rtag);
      n_run++;
      if (result !== exp_res) begin
         n_fail++;
         $display("FAIL %s op=%0d result act=%h exp=%h", rtag, op, result, exp_res);
      end
      n_run++;
      if (flags !== exp_fl) begin
         n_fail++;
         for (int i = 0; i < 9; i++)
            if (flags[i] !== exp_fl[i])
               $display("FAIL %s op=%0d flag bit %0d act=%b exp=%b (flags act=%b exp=%b)",
                        (op == 5 || op >= 12) ? "R10" : tag_of(i, op), op, i,
                        flags[i], exp_fl[i], flags, exp_fl);
      end
   endtask

   // one command: drive at falling edge, sample one falling edge later
   task automatic run(int op, bit wd, int a, int b, bit vld = 1'b1);
      @(negedge clk);
      op_valid = vld; op_code = 4'(op); wide = wd;
      opnd_a = 16'(a); opnd_b = 16'(b);
      if (vld) model(op, wd, a, b);
      @(negedge clk);
      op_valid = 1'b0;
      compare(op, vld ? "R2" : "R10");
   endtask

   initial begin
      #1_000_000;
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240917));
      repeat (3) @(negedge clk);
      compare(0, "R1");                 // R1 reset state
      rst_n = 1'b1;
      run(0, 0, 16'h007F, 16'h0001);    // R8 byte overflow, R7 sign, R5 aux
      run(0, 1, 16'hFFFF, 16'h0001);    // R3 word carry, R6 zero, R4 parity of 0
      run(1, 0, 16'h0000, 16'h0001);    // R3 borrow, R4 eight ones
      run(1, 1, 16'h8000, 16'h0001);    // R8 word subtract overflow
      run(0, 0, 16'h120F, 16'h3401);    // R2 upper byte ignored, R5 half carry
      run(2, 1, 16'hF0F0, 16'h0FF0);    // R9 logic clears
      run(4, 0, 16'h00FF, 16'h0000);    // R9 NOT to zero
      run(5, 1, 16'h1234, 16'hBEEF);    // R10 transfer keeps flags
      run(6, 0, 0, 0);                  // R11 set interrupt
      run(8, 0, 0, 0);                  // R11 set direction
      run(10, 0, 0, 0);                 // R11 set trap
      run(3, 1, 16'h8000, 16'h0001);    // R11 control bits kept by ALU op
      run(13, 1, 16'hFFFF, 16'hFFFF);   // R10 undefined code
      run(0, 1, 16'h1111, 16'h2222, 1'b0); // R10 idle cycle
      run(7, 0, 0, 0);                  // R11 clear interrupt
      run(1, 0, 16'h0010, 16'h0001);    // R5 borrow from bit 4
      for (int k = 0; k < 400; k++) begin
         int op = int'($urandom % 14);
         int a = int'($urandom % 65536);
         int b = int'($urandom % 65536);
         if (k % 8 == 0) b = int'($urandom % 4);
         run(op, 1'($urandom % 2), a, b, 1'(($urandom % 10) != 0));
      end
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule